// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading two entries from page tables held in memory. A requester presents the address together with two flags: whether the access is a write and whether it comes from user code. The directory base, which software reloads whenever the active address space changes, is sampled when the request is accepted. The walker reads the directory entry first. If that entry allows it, the walker then reads the table entry that the directory entry points to. It returns either the physical address or a fault code.

Memory is reached through a plain read port. The walker pulses a request with an address. The memory answers with a one-cycle valid and the data, at least one cycle after the request. Only one translation is in progress at a time. Every 32-bit entry uses the same layout: bit 0 marks the page present, bit 1 allows writes, bit 2 allows user access, and bits 31:12 give the frame number of the next level.

Top module: `pt_walker`

## Requirements
- R1: While reset is held low and in the cycle after it is released, `req_ready` is 1, and `rsp_valid` and `mem_req` are 0.
- R2: The first read of a walk goes to address {directory base[31:12], vaddr[31:22], 2'b00}.
- R3: A second read, to {directory entry[31:12], vaddr[21:12], 2'b00}, is issued only when the directory entry is present and permits the access.
- R4: A successful walk returns `rsp_fault` = 2'b00 and `rsp_paddr` = {table entry[31:12], vaddr[11:0]}. The 12-bit offset passes through unchanged.
- R5: A directory entry with bit 0 clear ends the walk after one read with `rsp_fault` = 2'b01 and `rsp_paddr` = 0.
- R6: A table entry with bit 0 clear gives `rsp_fault` = 2'b01 and `rsp_paddr` = 0.
- R7: A write to an entry with bit 1 clear, or a user access to an entry with bit 2 clear, gives `rsp_fault` = 2'b10 and `rsp_paddr` = 0, at whichever level this happens first. A supervisor read ignores bits 1 and 2. At the same level, a clear bit 0 takes precedence and gives 2'b01.
- R8: `req_ready` is 1 only while the walker is idle. It falls in the cycle after a request is accepted. A `req_valid` presented while `req_ready` is 0 is not accepted and does not change the walk in progress.
- R9: The directory base, address, write flag and user flag are sampled in the accept cycle. Later changes to them do not affect the walk in progress.
- R10: Each read is a one-cycle `mem_req` pulse, issued in the cycle after the accept or after the previous read's response. `rsp_valid` is a one-cycle pulse in the cycle after the last response, and `req_ready` returns in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and accepting a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access comes from user mode |
| dir_base | input | 32 | Directory base; bits 31:12 are used |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 32 | Address of the entry being read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Entry read from memory |
| rsp_valid | output | 1 | Result valid, one cycle |
| rsp_paddr | output | 32 | Physical address, zero on a fault |
| rsp_fault | output | 2 | 00 none, 01 not present, 10 protection |

## Verification
Translations are requested through a directory that holds a fully open entry, an absent entry, a supervisor-only entry and a read-only user entry. Each of these leads to tables with the same mix of attributes, so a fault raised at the directory can be told apart from one raised at the table, and the read count confirms which it was. Each such entry is hit by supervisor reads, supervisor writes, user reads and user writes, which separates the write check from the user check. An entry that is absent but otherwise open shows that absence wins. The first and last directory and table indices, and the offsets 0x000 and 0xFFF, check the index slicing and the offset pass-through. A second directory base, memory latencies of one and two cycles, inputs scrambled during a walk, and a request held high through a walk check the sampling and handshake timing.

// File: rtl/pt_walker_pkg.sv
// Package: shared types and entry layout for the page table walker.
// Assumes every table entry has the same width as a virtual address.
package pt_walker_pkg;

    // Positions of the attribute bits inside an entry.
    localparam int unsigned ENT_PRESENT = 0;
    localparam int unsigned ENT_WRITE   = 1;
    localparam int unsigned ENT_USER    = 2;
    localparam int unsigned ENT_FLAGS_W = 3;

    // Result code reported with each response.
    typedef enum logic [1:0] {
        FLT_NONE   = 2'b00,
        FLT_ABSENT = 2'b01,
        FLT_PROT   = 2'b10
    } fault_e;

    // Walk sequencer states.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIR_RD,
        ST_DIR_WT,
        ST_TBL_RD,
        ST_TBL_WT,
        ST_RESP
    } walk_state_e;

endpackage

// File: rtl/pt_entry_check.sv
// Entry checker: decides from the attribute bits of one entry whether the
// access may proceed. Presence is judged before permission. A supervisor
// read passes any present entry.
module pt_entry_check
    import pt_walker_pkg::*;
(
    input  logic [ENT_FLAGS_W-1:0] flags,
    input  logic                   is_write,
    input  logic                   is_user,
    output fault_e                 fault
);

    // Classify the entry: absent, protection violation, or allowed.
    always_comb begin
        if (!flags[ENT_PRESENT]) begin
            fault = FLT_ABSENT;
        end else if ((is_write && !flags[ENT_WRITE]) || (is_user && !flags[ENT_USER])) begin
            fault = FLT_PROT;
        end else begin
            fault = FLT_NONE;
        end
    end

endmodule

// File: rtl/pt_addr_gen.sv
// Entry address generator: forms the address of the directory entry or the
// table entry from a frame number and an index slice of the virtual address.
// Assumes VA_W == 2*IDX_W + OFF_W and that entries are 2**(OFF_W-IDX_W) bytes.
module pt_addr_gen #(
    parameter int unsigned VA_W  = 32,
    parameter int unsigned IDX_W = 10,
    parameter int unsigned OFF_W = 12
) (
    input  logic                    sel_tbl,
    input  logic [VA_W-OFF_W-1:0]   base_frame,
    input  logic [VA_W-OFF_W-1:0]   pde_frame,
    input  logic [VA_W-OFF_W-1:0]   vpn,
    output logic [VA_W-1:0]         entry_addr
);

    localparam int unsigned FRAME_W = VA_W - OFF_W;
    localparam int unsigned ENT_LG  = OFF_W - IDX_W;

    logic [IDX_W-1:0]   dir_idx;
    logic [IDX_W-1:0]   tbl_idx;
    logic [FRAME_W-1:0] frame;

    // Split the virtual page number into its two table indices.
    always_comb begin
        dir_idx = vpn[FRAME_W-1 -: IDX_W];
        tbl_idx = vpn[IDX_W-1:0];
    end

    // Choose the frame and index for the current level and scale the index.
    always_comb begin
        frame      = sel_tbl ? pde_frame : base_frame;
        entry_addr = {frame, (sel_tbl ? tbl_idx : dir_idx), {ENT_LG{1'b0}}};
    end

endmodule

// File: rtl/pt_walk_ctrl.sv
// Walk sequencer: steps through the two dependent reads of one translation.
// It issues a one-cycle read request, waits for the response, and then either
// goes to the next level or finishes. Assumes the memory response arrives at
// least one cycle after its request. A response seen outside a wait state is
// ignored.
module pt_walk_ctrl
    import pt_walker_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic mem_rvalid,
    input  logic entry_ok,
    output logic req_ready,
    output logic mem_req,
    output logic sel_tbl,
    output logic load_req,
    output logic load_pde,
    output logic load_rsp,
    output logic rsp_valid
);

    walk_state_e state_q;
    walk_state_e state_d;

    // Next-state choice for the walk sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_DIR_RD;
            ST_DIR_RD: state_d = ST_DIR_WT;
            ST_DIR_WT: if (mem_rvalid) state_d = entry_ok ? ST_TBL_RD : ST_RESP;
            ST_TBL_RD: state_d = ST_TBL_WT;
            ST_TBL_WT: if (mem_rvalid) state_d = ST_RESP;
            ST_RESP:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Decode the handshake signals and load enables from the state.
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        mem_req   = (state_q == ST_DIR_RD) || (state_q == ST_TBL_RD);
        sel_tbl   = (state_q == ST_TBL_RD) || (state_q == ST_TBL_WT);
        load_req  = (state_q == ST_IDLE) && req_valid;
        load_pde  = (state_q == ST_DIR_WT) && mem_rvalid && entry_ok;
        load_rsp  = ((state_q == ST_DIR_WT) && mem_rvalid && !entry_ok)
                 || ((state_q == ST_TBL_WT) && mem_rvalid);
        rsp_valid = (state_q == ST_RESP);
    end

endmodule

// File: rtl/pt_walker.sv
// Two-level page table walker top. It accepts one translation at a time,
// samples the request and the directory base in the accept cycle, reads the
// directory entry and then the table entry through a simple read port, and
// returns a physical address or a fault code. The entry checker judges each
// entry as it arrives, so permissions are enforced level by level.
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter int unsigned VA_W  = 32,
    parameter int unsigned IDX_W = 10,
    parameter int unsigned OFF_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [VA_W-1:0] req_vaddr,
    input  logic            req_write,
    input  logic            req_user,
    input  logic [VA_W-1:0] dir_base,
    output logic            mem_req,
    output logic [VA_W-1:0] mem_addr,
    input  logic            mem_rvalid,
    input  logic [VA_W-1:0] mem_rdata,
    output logic            rsp_valid,
    output logic [VA_W-1:0] rsp_paddr,
    output logic [1:0]      rsp_fault
);

    localparam int unsigned FRAME_W = VA_W - OFF_W;

    logic [VA_W-1:0]    va_q;
    logic               wr_q;
    logic               us_q;
    logic [FRAME_W-1:0] base_frame_q;
    logic [FRAME_W-1:0] pde_frame_q;
    logic [VA_W-1:0]    paddr_q;
    fault_e             fault_q;

    logic   sel_tbl;
    logic   load_req;
    logic   load_pde;
    logic   load_rsp;
    fault_e ent_fault;
    logic   unused_rdata_bits;

    // The frame bits and the attribute bits are used; the rest are reserved.
    assign unused_rdata_bits = ^mem_rdata[OFF_W-1:ENT_FLAGS_W];

    pt_walk_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .mem_rvalid (mem_rvalid),
        .entry_ok   (ent_fault == FLT_NONE),
        .req_ready  (req_ready),
        .mem_req    (mem_req),
        .sel_tbl    (sel_tbl),
        .load_req   (load_req),
        .load_pde   (load_pde),
        .load_rsp   (load_rsp),
        .rsp_valid  (rsp_valid)
    );

    pt_addr_gen #(
        .VA_W  (VA_W),
        .IDX_W (IDX_W),
        .OFF_W (OFF_W)
    ) u_addr (
        .sel_tbl    (sel_tbl),
        .base_frame (base_frame_q),
        .pde_frame  (pde_frame_q),
        .vpn        (va_q[VA_W-1:OFF_W]),
        .entry_addr (mem_addr)
    );

    pt_entry_check u_check (
        .flags    (mem_rdata[ENT_FLAGS_W-1:0]),
        .is_write (wr_q),
        .is_user  (us_q),
        .fault    (ent_fault)
    );

    // Capture the request and the directory base when the request is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q         <= '0;
            wr_q         <= 1'b0;
            us_q         <= 1'b0;
            base_frame_q <= '0;
        end else if (load_req) begin
            va_q         <= req_vaddr;
            wr_q         <= req_write;
            us_q         <= req_user;
            base_frame_q <= dir_base[VA_W-1:OFF_W];
        end
    end

    // Keep the frame of an accepted directory entry for the table read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pde_frame_q <= '0;
        end else if (load_pde) begin
            pde_frame_q <= mem_rdata[VA_W-1:OFF_W];
        end
    end

    // Register the final result; a fault forces the address to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            paddr_q <= '0;
            fault_q <= FLT_NONE;
        end else if (load_rsp) begin
            fault_q <= ent_fault;
            paddr_q <= (ent_fault == FLT_NONE)
                     ? {mem_rdata[VA_W-1:OFF_W], va_q[OFF_W-1:0]}
                     : '0;
        end
    end

    // Drive the result ports from the held result.
    always_comb begin
        rsp_paddr = paddr_q;
        rsp_fault = fault_q;
    end

endmodule

// File: rtl/pt_walker_chk.sv
// Checker for the page table walker: handshake timing, the first read
// address, and the shape of the result. It keeps its own copy of the
// accepted offset. It is attached to every walker instance by the bind at
// the end of this file.
module pt_walker_chk #(
    parameter int unsigned VA_W  = 32,
    parameter int unsigned IDX_W = 10,
    parameter int unsigned OFF_W = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic [VA_W-1:0] req_vaddr,
    input logic [VA_W-1:0] dir_base,
    input logic            mem_req,
    input logic [VA_W-1:0] mem_addr,
    input logic            rsp_valid,
    input logic [VA_W-1:0] rsp_paddr,
    input logic [1:0]      rsp_fault
);

    localparam int unsigned ENT_LG = OFF_W - IDX_W;

    logic [OFF_W-1:0] off_q;
    logic             rst_d;

    // Remember the offset of the accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_q <= '0;
        end else if (req_valid && req_ready) begin
            off_q <= req_vaddr[OFF_W-1:0];
        end
    end

    // Delayed reset, used to find the first cycle after reset is released.
    always_ff @(posedge clk) begin
        rst_d <= rst_n;
    end

    // R1: idle outputs in the first cycle after reset is released.
    always_ff @(posedge clk) begin
        if (rst_n && (rst_d == 1'b0)) begin
            a_r1_reset_idle: assert (req_ready && !rsp_valid && !mem_req)
                else $error("R1 outputs not idle after reset");
        end
    end

    // R8: the walker is busy in the cycle after an accept.
    a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R8: no memory read while idle.
    a_r8_idle_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req);

    // R10: each read request lasts one cycle.
    a_r10_read_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    // R10: the response lasts one cycle and the walker is idle after it.
    a_r10_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));

    // R2: the first read goes to the directory entry of the accepted request.
    a_r2_dir_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (mem_req &&
            mem_addr == {$past(dir_base[VA_W-1:OFF_W]), $past(req_vaddr[VA_W-1 -: IDX_W]), {ENT_LG{1'b0}}}));

    // R4: a successful result carries the accepted offset.
    a_r4_offset: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == 2'b00) |-> (rsp_paddr[OFF_W-1:0] == off_q));

    // R5: a faulting result carries a zero address.
    a_r5_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != 2'b00) |-> (rsp_paddr == '0));

    // R7: the unused code 11 never appears.
    a_r7_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_fault != 2'b11));

endmodule

bind pt_walker pt_walker_chk #(
    .VA_W  (VA_W),
    .IDX_W (IDX_W),
    .OFF_W (OFF_W)
) u_pt_walker_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_vaddr (req_vaddr),
    .dir_base  (dir_base),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .rsp_valid (rsp_valid),
    .rsp_paddr (rsp_paddr),
    .rsp_fault (rsp_fault)
);

// File: tb/pt_walker_tb.sv
// Bench for the page table walker: a memory with adjustable latency, a
// behavioural reference that counts the busy cycles of each walk, and a
// comparison on every falling edge.
module pt_walker_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic [31:0] dir_base = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid;
    logic [31:0] mem_rdata;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic [1:0]  rsp_fault;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit run_model = 0;
    int lat = 1;
    string cur_tag = "R4";

    always #2 clk = ~clk;

    pt_walker dut_i (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_ready (req_ready), .req_vaddr (req_vaddr),
        .req_write (req_write), .req_user (req_user), .dir_base (dir_base),
        .mem_req (mem_req), .mem_addr (mem_addr), .mem_rvalid (mem_rvalid),
        .mem_rdata (mem_rdata), .rsp_valid (rsp_valid), .rsp_paddr (rsp_paddr),
        .rsp_fault (rsp_fault)
    );

    // Memory image; a missing word reads as zero (not present).
    logic [31:0] mem [int unsigned];

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    // Memory responder with a latency of one or two cycles.
    logic [1:0]  rv_pipe = '0;
    logic [31:0] ad0 = '0, ad1 = '0;
    always @(posedge clk) begin
        if (!rst_n) begin
            rv_pipe <= '0;
        end else begin
            rv_pipe <= {rv_pipe[0], mem_req};
            ad0 <= mem_addr;
            ad1 <= ad0;
        end
    end
    assign mem_rvalid = (lat == 1) ? rv_pipe[0] : rv_pipe[1];
    assign mem_rdata  = rd((lat == 1) ? ad0 : ad1);

    function automatic logic [31:0] mkva(input int d, input int t, input int o);
        return {d[9:0], t[9:0], o[11:0]};
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Reference walk computed from the entry layout and the requirements.
    task automatic ref_walk(input logic [31:0] va, input logic [31:0] base,
                            input bit wr, input bit us,
                            output logic [31:0] pa, output logic [1:0] flt,
                            output int nrd, output logic [31:0] a0, output logic [31:0] a1);
        logic [31:0] e;
        a0 = {base[31:12], va[31:22], 2'b00};
        a1 = '0;
        pa = '0;
        nrd = 1;
        e = rd(a0);
        if (!e[0]) flt = 2'b01;
        else if ((wr && !e[1]) || (us && !e[2])) flt = 2'b10;
        else begin
            a1 = {e[31:12], va[21:12], 2'b00};
            nrd = 2;
            e = rd(a1);
            if (!e[0]) flt = 2'b01;
            else if ((wr && !e[1]) || (us && !e[2])) flt = 2'b10;
            else begin
                flt = 2'b00;
                pa = {e[31:12], va[11:0]};
            end
        end
    endtask

    // Reference state: remaining busy cycles and the expected walk.
    int cnt = 0, tot = 0, m_nrd = 0, m_lat = 1;
    logic [31:0] m_pa, m_a0, m_a1;
    logic [1:0]  m_flt;
    string m_tag = "R4";

    // Compare all outputs on every cycle, then advance the reference.
    always @(negedge clk) begin
        if (rst_n && run_model) begin
            bit exp_mreq;
            chk(req_ready === (cnt == 0), "R8", "req_ready", {31'b0, req_ready}, {31'b0, cnt == 0});
            chk(rsp_valid === (cnt == 1), "R10", "rsp_valid", {31'b0, rsp_valid}, {31'b0, cnt == 1});
            exp_mreq = (cnt != 0) && ((cnt == tot) || (m_nrd == 2 && cnt == tot - 1 - m_lat));
            chk(mem_req === exp_mreq, (cnt == tot) ? "R2" : "R3", "mem_req",
                {31'b0, mem_req}, {31'b0, exp_mreq});
            if (mem_req && exp_mreq) begin
                if (cnt == tot) chk(mem_addr === m_a0, "R2", "dir entry addr", mem_addr, m_a0);
                else            chk(mem_addr === m_a1, "R3", "tbl entry addr", mem_addr, m_a1);
            end
            if (rsp_valid && cnt == 1) begin
                chk(rsp_fault === m_flt, m_tag, "fault code", {30'b0, rsp_fault}, {30'b0, m_flt});
                chk(rsp_paddr === m_pa, m_tag, "paddr", rsp_paddr, m_pa);
            end
            if (cnt == 0) begin
                if (req_valid) begin
                    ref_walk(req_vaddr, dir_base, req_write, req_user, m_pa, m_flt, m_nrd, m_a0, m_a1);
                    m_lat = lat;
                    m_tag = cur_tag;
                    tot = m_nrd * (1 + lat) + 1;
                    cnt = tot;
                end
            end else begin
                cnt--;
            end
        end
    end

    // Issue one request; optionally scramble the inputs or hold valid high
    // while the walk runs.
    task automatic issue(input logic [31:0] base, input logic [31:0] va, input bit wr,
                         input bit us, input string tag, input bit scramble, input bit hold);
        @(posedge clk); #1;
        cur_tag = tag;
        dir_base = base; req_vaddr = va; req_write = wr; req_user = us; req_valid = 1'b1;
        @(posedge clk); #1;
        if (scramble) begin
            dir_base = 32'hDEAD_0000; req_vaddr = ~va; req_write = ~wr; req_user = ~us;
        end
        if (hold) begin
            cur_tag = "R8";
            req_vaddr = mkva(1, 0, 12'h777); req_write = 1'b0; req_user = 1'b0;
            dir_base = base;
        end else begin
            req_valid = 1'b0;
        end
        do @(negedge clk); while (!req_ready);
        if (hold) begin
            @(posedge clk); #1;
            req_valid = 1'b0;
            do @(negedge clk); while (!req_ready);
        end
    endtask

    localparam logic [31:0] B1 = 32'h0004_0000;
    localparam logic [31:0] B2 = 32'h000A_0000;

    initial begin
        // Directory at B1.
        mem[B1 + 4*1]    = 32'h0005_0007;
        mem[B1 + 4*2]    = 32'h0006_0006;
        mem[B1 + 4*3]    = 32'h0007_0003;
        mem[B1 + 4*4]    = 32'h0008_0005;
        mem[B1 + 4*1023] = 32'h0009_0007;
        // Tables.
        mem[32'h0005_0000 + 4*0]    = 32'hABCD_E007;
        mem[32'h0005_0000 + 4*1]    = 32'h1234_5005;
        mem[32'h0005_0000 + 4*2]    = 32'h2222_2003;
        mem[32'h0005_0000 + 4*3]    = 32'h3333_3006;
        mem[32'h0005_0000 + 4*1023] = 32'hFFFF_F007;
        mem[32'h0007_0000]          = 32'h4444_4007;
        mem[32'h0008_0000]          = 32'h5555_5007;
        mem[32'h0009_0000 + 4*5]    = 32'h6666_6007;
        // Second address space.
        mem[B2 + 4*1]      = 32'h000B_0007;
        mem[32'h000B_0000] = 32'h7777_7007;

        // R1: reset state.
        repeat (3) @(posedge clk);
        #1;
        chk(req_ready === 1'b1, "R1", "ready in reset", {31'b0, req_ready}, 32'd1);
        chk(rsp_valid === 1'b0, "R1", "rsp_valid in reset", {31'b0, rsp_valid}, 32'd0);
        chk(mem_req === 1'b0, "R1", "mem_req in reset", {31'b0, mem_req}, 32'd0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        run_model = 1'b1;
        @(negedge clk);
        chk(req_ready === 1'b1 && rsp_valid === 1'b0 && mem_req === 1'b0, "R1", "idle after reset",
            {29'b0, req_ready, rsp_valid, mem_req}, 32'd4);

        issue(B1, mkva(1, 0, 12'h123), 0, 0, "R4", 0, 0);
        issue(B1, mkva(1, 1023, 12'h000), 1, 1, "R4", 0, 0);
        issue(B1, mkva(1023, 5, 12'hFFF), 0, 1, "R4", 0, 0);
        issue(B1, mkva(1, 1, 12'hFFF), 0, 1, "R7", 0, 0);
        issue(B1, mkva(1, 1, 12'h010), 1, 1, "R7", 0, 0);
        issue(B1, mkva(1, 1, 12'h010), 1, 0, "R7", 0, 0);
        issue(B1, mkva(1, 2, 12'h000), 1, 0, "R7", 0, 0);
        issue(B1, mkva(1, 2, 12'h000), 0, 1, "R7", 0, 0);
        issue(B1, mkva(1, 3, 12'h5A5), 0, 0, "R6", 0, 0);
        issue(B1, mkva(1, 3, 12'h5A5), 1, 1, "R6", 0, 0);
        issue(B1, mkva(2, 0, 12'h001), 0, 0, "R5", 0, 0);
        issue(B1, mkva(0, 0, 12'h001), 0, 0, "R5", 0, 0);
        issue(B1, mkva(3, 0, 12'hABC), 0, 1, "R7", 0, 0);
        issue(B1, mkva(3, 0, 12'hABC), 1, 0, "R4", 0, 0);
        issue(B1, mkva(4, 0, 12'h00F), 1, 1, "R7", 0, 0);
        issue(B1, mkva(4, 0, 12'h00F), 0, 1, "R4", 0, 0);

        // R9: second address space, then inputs scrambled during the walk.
        issue(B2, mkva(1, 0, 12'h456), 0, 0, "R9", 0, 0);
        issue(B2, mkva(1, 0, 12'h456), 0, 1, "R9", 1, 0);
        issue(B1, mkva(1, 0, 12'h321), 1, 1, "R9", 1, 0);

        // R8: valid held high through a walk with a different address.
        issue(B1, mkva(1, 1023, 12'h800), 0, 0, "R8", 0, 1);

        // R10: two-cycle memory latency.
        lat = 2;
        issue(B1, mkva(1, 0, 12'h0F0), 0, 0, "R10", 0, 0);
        issue(B1, mkva(2, 0, 12'h0F0), 0, 0, "R10", 0, 0);
        issue(B1, mkva(3, 0, 12'h0F0), 0, 1, "R10", 0, 0);
        lat = 1;

        repeat (4) @(negedge clk);
        chk(cnt == 0, "R10", "reference idle at end", cnt, 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung walk ends the run as a failure.
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R8 watchdog actual=hung expected=complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule